// File: doc/BRIEF.md
# Tone-Pair Steering Validator

This block replaces the resistor-capacitor steering network of a tone-pair receiver with counters. A frequency detector upstream raises an early-steering level while it sees a valid pair, and presents the 4-bit code of that pair. The validator times that level against a timebase tick. A pair is accepted only if the level holds for a programmable tone-present guard time. A new pair is allowed only after the level has stayed low for a separate tone-absent guard time. Each guard time is given as a number of ticks on its own input port.

On acceptance the validator latches the code into its receive register first. It raises the delayed-steering flag a fixed number of clock cycles later, so that the data has settled before anyone looks at it. A one-cycle registration pulse comes with the rising flag, for the status logic that keeps the receive-full bit. Selecting call-progress mode holds the validator idle.

The controller has five states:
- ST_IDLE: waiting for early steering.
- ST_ACQUIRE: timing tone presence.
- ST_SETTLE: the code is latched and the flag is not yet raised.
- ST_HELD: the pair is registered.
- ST_RELEASE: timing tone absence.

Its transitions are:
- IDLE to ACQUIRE when early steering rises.
- ACQUIRE back to IDLE when early steering drops before the present guard expires.
- ACQUIRE to SETTLE when the present guard expires.
- SETTLE to HELD when the settle delay ends.
- HELD to RELEASE when early steering drops.
- RELEASE back to HELD when early steering returns before the absent guard expires.
- RELEASE to IDLE when the absent guard expires.
- Any state to IDLE while call-progress mode is selected.

Top module: `tone_steer_validator`

## Requirements
- R1: A code is latched only when early steering has stayed high from its rise through `present_guard` ticks. The ticks are counted from the cycle after the rise, and a guard of 0 behaves as 1. A shorter burst leaves `rx_code` unchanged and gives no `reg_pulse`.
- R2: After a registration, `dly_steer` falls only once early steering has stayed low for `absent_guard` ticks. Only after that can a new pair be registered.
- R3: A drop of early steering that lasts fewer than `absent_guard` ticks during a registered tone is bridged. `rx_code` and `dly_steer` are unchanged, and no new `reg_pulse` occurs when the tone resumes.
- R4: `rx_code` holds its value until the next registration. A change of `code_in` while the pair stays registered has no effect.
- R5: `rx_code` takes `code_in` at the clock edge where the present guard expires. `dly_steer` rises SETTLE_CYC clock edges later. `reg_pulse` is high for exactly the one cycle in which `dly_steer` first reads high.
- R6: If early steering changes level before a guard expires, that guard's count restarts from zero. Two short bursts separated by a one-cycle gap never add up to an acceptance.
- R7: While `cp_mode` is high, the block is held idle. `dly_steer` is cleared one edge later, no code is registered, and `rx_code` keeps its value.
- R8: After reset, `rx_code` is 0 and `dly_steer` and `reg_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Timebase strobe, one cycle per guard unit |
| est | input | 1 | Early steering: high while a valid pair is detected |
| code_in | input | 4 | Decoded code of the current pair |
| cp_mode | input | 1 | Call-progress mode select; holds steering idle |
| present_guard | input | GW | Tone-present guard time in ticks |
| absent_guard | input | GW | Tone-absent guard time in ticks |
| rx_code | output | 4 | Latched receive code |
| reg_pulse | output | 1 | One-cycle pulse on each registration |
| dly_steer | output | 1 | Delayed-steering flag |

## Verification
The bench builds the block with GW = 6 and SETTLE_CYC = 3, and a tick every fourth clock. With a present guard of 5 and an absent guard of 4, a full accept or release takes about twenty cycles. That brings short bursts, one-cycle restarts and bridged drop-outs within a few hundred cycles. The three-cycle settle makes the latch-before-flag ordering visible as distinct edges. Reprogramming the guards to 0 and 1 reaches the degenerate one-tick thresholds.

// File: rtl/steer_pkg.sv
package steer_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACQUIRE,
        ST_SETTLE,
        ST_HELD,
        ST_RELEASE
    } steer_state_e;
endpackage

// File: rtl/steer_guard_cnt.sv
// Counts timebase ticks while enabled; hit marks the tick that reaches limit.
module steer_guard_cnt #(
    parameter int GW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick,
    input  logic [GW-1:0] limit,
    output logic          hit
);
    logic [GW-1:0] cnt;
    logic [GW:0]   nxt;

    assign nxt = {1'b0, cnt} + {{GW{1'b0}}, 1'b1};
    assign hit = tick && !clr && (nxt >= {1'b0, limit});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && !hit) begin
            cnt <= nxt[GW-1:0];
        end
    end
endmodule

// File: rtl/steer_settle_tmr.sv
// Counts clock cycles while enabled; done on the last cycle of the delay.
module steer_settle_tmr #(
    parameter int CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int CW = (CYC > 1) ? $clog2(CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYC - 1);

    logic [CW-1:0] cnt;

    assign done = !clr && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tone_steer_validator.sv
module tone_steer_validator
    import steer_pkg::*;
#(
    parameter int GW         = 16,
    parameter int SETTLE_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          est,
    input  logic [3:0]    code_in,
    input  logic          cp_mode,
    input  logic [GW-1:0] present_guard,
    input  logic [GW-1:0] absent_guard,
    output logic [3:0]    rx_code,
    output logic          reg_pulse,
    output logic          dly_steer
);
    steer_state_e state, state_nx;
    logic acq_hit, rel_hit, settle_done;

    steer_guard_cnt #(.GW(GW)) u_present (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_ACQUIRE),
        .tick(tick), .limit(present_guard), .hit(acq_hit)
    );

    steer_guard_cnt #(.GW(GW)) u_absent (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_RELEASE),
        .tick(tick), .limit(absent_guard), .hit(rel_hit)
    );

    steer_settle_tmr #(.CYC(SETTLE_CYC)) u_settle (
        .clk(clk), .rst_n(rst_n), .clr(state != ST_SETTLE),
        .done(settle_done)
    );

    always_comb begin
        state_nx = state;
        if (cp_mode) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:    if (est) state_nx = ST_ACQUIRE;
                ST_ACQUIRE: begin
                    if (!est)         state_nx = ST_IDLE;
                    else if (acq_hit) state_nx = ST_SETTLE;
                end
                ST_SETTLE:  if (settle_done) state_nx = ST_HELD;
                ST_HELD:    if (!est) state_nx = ST_RELEASE;
                ST_RELEASE: begin
                    if (est)          state_nx = ST_HELD;
                    else if (rel_hit) state_nx = ST_IDLE;
                end
                default:    state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_code   <= 4'h0;
            dly_steer <= 1'b0;
            reg_pulse <= 1'b0;
        end else begin
            reg_pulse <= 1'b0;
            if (cp_mode) begin
                dly_steer <= 1'b0;
            end else begin
                unique case (state)
                    ST_ACQUIRE: if (est && acq_hit) rx_code <= code_in;
                    ST_SETTLE:  if (settle_done) begin
                        dly_steer <= 1'b1;
                        reg_pulse <= 1'b1;
                    end
                    ST_RELEASE: if (!est && rel_hit) dly_steer <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_pulse |=> !reg_pulse); // R5
    AST_PULSE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_pulse |-> (dly_steer && !$past(dly_steer))); // R5
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_steer && $past(dly_steer)) |-> $stable(rx_code)); // R4
    AST_CP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cp_mode |=> (!dly_steer && !reg_pulse)); // R7
    AST_FALL_AFTER_ABSENCE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dly_steer) |-> ($past(!est) || $past(cp_mode))); // R2
endmodule

// File: tb/tone_steer_validator_test.sv
module tone_steer_validator_test;
    localparam int GW = 6;
    localparam int SC = 3;

    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, est = 1'b0, cp_mode = 1'b0;
    logic [3:0] code_in = 4'h0;
    logic [GW-1:0] present_guard = 6'd5, absent_guard = 6'd4;
    logic [3:0] rx_code;
    logic reg_pulse, dly_steer;

    int tests = 0, fails = 0, pulses = 0;
    bit finished = 1'b0;
    string cur_req = "R8";

    tone_steer_validator #(.GW(GW), .SETTLE_CYC(SC)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .est(est), .code_in(code_in),
        .cp_mode(cp_mode), .present_guard(present_guard),
        .absent_guard(absent_guard), .rx_code(rx_code),
        .reg_pulse(reg_pulse), .dly_steer(dly_steer)
    );

    always #4 clk = ~clk;

    // Behavioural reference: phase 0 idle, 1 timing presence, 2 settling,
    // 3 registered, 4 timing absence.
    int m_phase = 0, m_ticks = 0, m_wait = 0;
    int m_rx = 0, m_flag = 0, m_pulse = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_rx = 0; m_flag = 0; m_pulse = 0;
        end else begin
            m_pulse = 0;
            if (cp_mode) begin
                m_phase = 0; m_flag = 0;
            end else if (m_phase == 0) begin
                if (est) begin m_phase = 1; m_ticks = 0; end
            end else if (m_phase == 1) begin
                if (!est) m_phase = 0;
                else if (tick) begin
                    if (m_ticks + 1 >= int'(present_guard)) begin
                        m_rx = int'(code_in); m_phase = 2; m_wait = 0;
                    end else m_ticks++;
                end
            end else if (m_phase == 2) begin
                if (m_wait == SC - 1) begin
                    m_phase = 3; m_flag = 1; m_pulse = 1;
                end else m_wait++;
            end else if (m_phase == 3) begin
                if (!est) begin m_phase = 4; m_ticks = 0; end
            end else begin
                if (est) m_phase = 3;
                else if (tick) begin
                    if (m_ticks + 1 >= int'(absent_guard)) begin
                        m_phase = 0; m_flag = 0;
                    end else m_ticks++;
                end
            end
        end
    end

    task automatic chk(string req, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk({cur_req, " model rx_code"}, int'(rx_code), m_rx);
            chk({cur_req, " model dly_steer"}, int'(dly_steer), m_flag);
            chk({cur_req, " model reg_pulse"}, int'(reg_pulse), m_pulse);
            if (reg_pulse) pulses++;
        end
    end

    initial begin
        int div = 0;
        forever begin
            @(posedge clk); #2;
            div = (div + 1) % 4;
            tick = (div == 0);
        end
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got 0 expected 1 (run completed)");
        summary();
    end

    initial begin
        int n;
        cyc(5);
        chk("R8 reset rx_code", int'(rx_code), 0);
        chk("R8 reset dly_steer", int'(dly_steer), 0);
        chk("R8 reset reg_pulse", int'(reg_pulse), 0);
        rst_n = 1'b1;
        cyc(3);

        cur_req = "R1";
        code_in = 4'h5; est = 1'b1; cyc(12); est = 1'b0; cyc(4);
        chk("R1 short burst rx_code", int'(rx_code), 0);
        chk("R1 short burst pulses", pulses, 0);

        cur_req = "R6";
        est = 1'b1; cyc(12); est = 1'b0; cyc(1); est = 1'b1; cyc(12);
        est = 1'b0; cyc(4);
        chk("R6 restart rx_code", int'(rx_code), 0);
        chk("R6 restart pulses", pulses, 0);

        cur_req = "R5";
        code_in = 4'h7; est = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (rx_code != 4'h7 && n < 100);
        chk("R5 latched code", int'(rx_code), 7);
        n = 0;
        while (!dly_steer && n < 20) begin @(negedge clk); n++; end
        chk("R5 settle edges", n, SC);
        chk("R5 pulse with flag", int'(reg_pulse), 1);
        @(negedge clk);
        chk("R5 pulse width", int'(reg_pulse), 0);
        cyc(8);
        chk("R1 registered flag", int'(dly_steer), 1);
        chk("R1 registered pulses", pulses, 1);

        cur_req = "R3";
        est = 1'b0; cyc(8); est = 1'b1; cyc(8);
        chk("R3 dropout rx_code", int'(rx_code), 7);
        chk("R3 dropout flag", int'(dly_steer), 1);
        chk("R3 dropout pulses", pulses, 1);

        cur_req = "R4";
        code_in = 4'h9; cyc(40);
        chk("R4 held rx_code", int'(rx_code), 7);
        chk("R4 held pulses", pulses, 1);

        cur_req = "R2";
        est = 1'b0; cyc(8);
        chk("R2 flag before absent guard", int'(dly_steer), 1);
        cyc(24);
        chk("R2 flag after absent guard", int'(dly_steer), 0);
        code_in = 4'hA; est = 1'b1; cyc(40);
        chk("R2 new pair rx_code", int'(rx_code), 10);
        chk("R2 new pair pulses", pulses, 2);
        est = 1'b0; cyc(30);

        cur_req = "R7";
        cp_mode = 1'b1; code_in = 4'h3; est = 1'b1; cyc(40);
        chk("R7 cp rx_code", int'(rx_code), 10);
        chk("R7 cp flag", int'(dly_steer), 0);
        chk("R7 cp pulses", pulses, 2);
        cp_mode = 1'b0; cyc(40);
        chk("R1 after cp rx_code", int'(rx_code), 3);
        chk("R1 after cp flag", int'(dly_steer), 1);
        cp_mode = 1'b1; cyc(2);
        chk("R7 cp clears flag", int'(dly_steer), 0);
        chk("R7 cp keeps rx_code", int'(rx_code), 3);
        cp_mode = 1'b0; est = 1'b0; cyc(30);

        cur_req = "R1";
        present_guard = 6'd0; absent_guard = 6'd1;
        code_in = 4'hC; est = 1'b1; cyc(12);
        chk("R1 zero guard rx_code", int'(rx_code), 12);
        cur_req = "R2";
        est = 1'b0; cyc(8);
        chk("R2 one-tick release", int'(dly_steer), 0);
        cyc(4);
        summary();
    end
endmodule